// File: doc/BRIEF.md
# Counter-Ramp Converter Controller

This block is the digital half of a counter-ramp analog-to-digital converter. It drives a binary code to an external DAC and reads back one comparator bit. The comparator is high once the DAC test level has reached the unknown input. The block then records the code that first produced that condition. The ramp can climb from zero or fall from full scale. It advances one step per tick of a programmable divider, so a slow DAC has time to settle. A conversion therefore takes longer for inputs that lie far from the ramp's starting point.

Two capture policies are offered. In restart mode, every capture sends the counter back to its start value and a new ramp begins at once. If the ramp reaches its far end without a trip, it reports the end value. In free-running mode, the counter wraps without interruption, and a result is captured on each rising edge of the synchronized comparator. The comparator bit is asynchronous. It passes through a two-flop synchronizer, and a matching delay line on the code keeps each comparator sample paired with the code that caused it.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While reset is held, `dac_code`, `result` and `valid` are all zero.
- R2: Once a ramp is under way, the code changes by exactly one step (+1 going up, -1 going down) every `tick_div`+1 clocks. After every restart the code first holds its start value for three clocks.
- R3: The comparator bit must read 1 when the test level is at or past the input: at or above it for an up ramp (`dir_down`=0), at or below it for a down ramp (`dir_down`=1). It is synchronized by two flops, and `result` is the code that first produced a 1, whatever the step rate.
- R4: With `feedback`=1, each capture reloads the start value (0 up, 255 down) in the same cycle `valid` rises. The capture interval is 4 clocks when the start code already trips, and otherwise 6 + n·(`tick_div`+1) clocks, where n is the number of steps from the start code to the tripping code.
- R5: With `feedback`=1, a ramp that reaches its end value (255 up, 0 down) without a trip reports that end value with `valid`, then restarts. The interval is the one R4 gives for n = 255.
- R6: With `feedback`=0, the counter wraps (255 to 0 up, 0 to 255 down) and is never reset by a capture. A result is captured on each rising edge of the synchronized comparator, one every 256·(`tick_div`+1) clocks for a constant input.
- R7: `valid` is a single-cycle pulse, high in the cycle in which `result` takes its new value. `result` does not change in any other cycle.
- R8: While `run_en` is low, `dac_code` sits at the start value for the selected direction and `valid` stays low.
- R9: A change of `dir_down` or `feedback` while running restarts the ramp. On the next clock the code is the start value of the new direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Converts continuously while high; holds the ramp at its start while low |
| dir_down | input | 1 | 0: up ramp from 0; 1: down ramp from 255 |
| feedback | input | 1 | 1: restart on capture; 0: free-running with wrap |
| tick_div | input | 8 | Step period minus one, in clocks |
| cmp_in | input | 1 | Asynchronous comparator bit, 1 when the test level has reached the input |
| dac_code | output | 8 | Code driven to the DAC |
| result | output | 8 | Last captured code |
| valid | output | 1 | One-cycle pulse marking a new `result` |

## Verification
A misaligned code delay line or synchronizer shows up in the first capture as a `result` that is off by the number of steps taken during the pipeline latency. The error is clearest with `tick_div`=0, where every clock is one step. A wrong blanking count or a restart that fails to fire changes the interval between `valid` pulses by a few clocks, or makes a small input report a neighbouring code. Both show within one conversion period. A counter that fails to saturate or wrap shows as a missing `valid` or a wrong end value within 256 steps.

// File: rtl/ramp_adc_pkg.sv
// Shared types for the counter-ramp converter controller.
// Assumes: included first in compile order.
package ramp_adc_pkg;

    // Run configuration sampled each clock; a change forces a restart.
    typedef struct packed {
        logic dir_down;
        logic feedback;
    } radc_cfg_t;

    // Reason a capture fires, used to steer the capture decision.
    typedef enum logic [1:0] {
        CAP_NONE  = 2'd0,
        CAP_LEVEL = 2'd1,
        CAP_EDGE  = 2'd2,
        CAP_END   = 2'd3
    } radc_cap_e;

endpackage

// File: rtl/radc_sync.sv
// Multi-flop synchronizer for one asynchronous bit.
// Assumes: STAGES >= 2; output is low during reset.
module radc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the raw bit through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/radc_tick.sv
// Step-rate divider: raises tick once every div+1 clocks while not held.
// Assumes: hold forces a fresh count from zero on the following cycle.
module radc_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    // Tick on reaching the programmed limit; >= tolerates a lowered limit.
    assign tick = !hold && (cnt >= div);

    // Count clocks between ticks; restart from zero on hold or tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (hold || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/radc_ramp.sv
// Up/down ramp counter that drives the DAC code.
// Assumes: restart has priority over step; saturate selects hold-at-end
// instead of wrap.
module radc_ramp #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic              dir_down,
    input  logic              saturate,
    output logic [CODE_W-1:0] code
);

    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    logic [CODE_W-1:0] start_val;
    logic [CODE_W-1:0] end_val;
    logic              at_end;

    // Start and end points of the current direction.
    always_comb begin
        start_val = dir_down ? CODE_MAX : '0;
        end_val   = dir_down ? '0 : CODE_MAX;
        at_end    = (code == end_val);
    end

    // Load the start value, step once per tick, or hold at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
        end else if (restart) begin
            code <= start_val;
        end else if (step && !(saturate && at_end)) begin
            code <= dir_down ? (code - CODE_W'(1)) : (code + CODE_W'(1));
        end
    end

endmodule

// File: rtl/radc_capture.sv
// Synchronizes the comparator, aligns the code with it, decides captures and
// registers the result with its valid pulse.
// Assumes: abort and restart come from the parent; restart includes the
// capture-driven restart; the blanking window covers synchronizer + edge flop.
module radc_capture
    import ramp_adc_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              restart,
    input  logic              dir_down,
    input  logic              feedback,
    input  logic [CODE_W-1:0] code,
    input  logic              cmp_raw,
    output logic              settled,
    output logic              fire,
    output logic [CODE_W-1:0] result,
    output logic              valid
);

    localparam int                BLANK    = SYNC_STAGES + 1;
    localparam int                BW       = $clog2(BLANK + 1);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    logic              cmp_s;
    logic              cmp_p;
    logic [CODE_W-1:0] dly [SYNC_STAGES];
    logic [CODE_W-1:0] code_al;
    logic [BW-1:0]     blank;
    logic              at_end_al;
    radc_cap_e         cause;

    radc_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (cmp_raw),
        .q    (cmp_s)
    );

    // Code delay line, one stage per synchronizer flop.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_dly
        // Move the code one stage further, in step with the synchronizer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dly[g] <= '0;
            end else if (g == 0) begin
                dly[g] <= code;
            end else begin
                dly[g] <= dly[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign code_al   = dly[SYNC_STAGES-1];
    assign settled   = (blank == '0);
    assign at_end_al = (code_al == (dir_down ? '0 : CODE_MAX));

    // Pick the capture cause from the aligned comparator and code.
    always_comb begin
        cause = CAP_NONE;
        if (settled && !abort) begin
            if (feedback) begin
                if (cmp_s) begin
                    cause = CAP_LEVEL;
                end else if (at_end_al) begin
                    cause = CAP_END;
                end
            end else if (cmp_s && !cmp_p) begin
                cause = CAP_EDGE;
            end
        end
    end

    assign fire = (cause != CAP_NONE);

    // Remember the previous synchronized comparator for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_p <= 1'b0;
        end else begin
            cmp_p <= cmp_s;
        end
    end

    // Blank decisions until the pipeline holds post-restart samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blank <= BW'(BLANK);
        end else if (restart) begin
            blank <= BW'(BLANK);
        end else if (!settled) begin
            blank <= blank - BW'(1);
        end
    end

    // Register the captured code and its one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= fire;
            if (fire) begin
                result <= code_al;
            end
        end
    end

endmodule

// File: rtl/ramp_adc_ctrl.sv
// Counter-ramp converter controller: ramps a DAC code, watches a comparator
// and captures the tripping code in restart or free-running mode.
// Assumes: the comparator reads 1 once the test level has reached the input
// in the selected direction; code holds at its start during blanking.
module ramp_adc_ctrl
    import ramp_adc_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              dir_down,
    input  logic              feedback,
    input  logic [DIV_W-1:0]  tick_div,
    input  logic              cmp_in,
    output logic [CODE_W-1:0] dac_code,
    output logic [CODE_W-1:0] result,
    output logic              valid
);

    radc_cfg_t cfg_now;
    radc_cfg_t cfg_q;
    logic      cfg_change;
    logic      abort;
    logic      restart;
    logic      settled;
    logic      fire;
    logic      tick;

    assign cfg_now    = '{dir_down: dir_down, feedback: feedback};
    assign cfg_change = (cfg_now != cfg_q);
    assign abort      = !run_en || cfg_change;
    assign restart    = abort || (fire && feedback);

    // Keep last cycle's configuration to spot mode or direction changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_now;
        end
    end

    radc_tick #(
        .DIV_W(DIV_W)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .hold (restart || !settled),
        .div  (tick_div),
        .tick (tick)
    );

    radc_ramp #(
        .CODE_W(CODE_W)
    ) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .step    (tick),
        .dir_down(dir_down),
        .saturate(feedback),
        .code    (dac_code)
    );

    radc_capture #(
        .CODE_W     (CODE_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort   (abort),
        .restart (restart),
        .dir_down(dir_down),
        .feedback(feedback),
        .code    (dac_code),
        .cmp_raw (cmp_in),
        .settled (settled),
        .fire    (fire),
        .result  (result),
        .valid   (valid)
    );

endmodule

// File: rtl/ramp_adc_ctrl_chk.sv
// Port-level checks for ramp_adc_ctrl, bound into every instance.
// Assumes: synchronous active-low reset held for at least two clocks.
module ramp_adc_ctrl_chk #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              dir_down,
    input logic              feedback,
    input logic [CODE_W-1:0] dac_code,
    input logic [CODE_W-1:0] result,
    input logic              valid
);

    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    // R7: valid never lasts two cycles.
    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R7: result only moves in a valid cycle.
    assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(result));

    // R2: the code moves by one step or jumps to a start value.
    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> (dac_code == $past(dac_code) + CODE_W'(1))
                            || (dac_code == $past(dac_code) - CODE_W'(1))
                            || (dac_code == '0) || (dac_code == CODE_MAX));

    // R8: idle holds the start value and produces no capture.
    assert_idle_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (dac_code == ($past(dir_down) ? CODE_MAX : '0)) && !valid);

    // R4: a capture in restart mode reloads the start value.
    assert_capture_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(feedback)) |-> (dac_code == ($past(dir_down) ? CODE_MAX : '0)));

    // R9: a direction change restarts at the new start value.
    assert_dir_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (dir_down != $past(dir_down))) |=>
            (dac_code == ($past(dir_down) ? CODE_MAX : '0)));

endmodule

bind ramp_adc_ctrl ramp_adc_ctrl_chk #(
    .CODE_W(CODE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .dir_down(dir_down),
    .feedback(feedback),
    .dac_code(dac_code),
    .result  (result),
    .valid   (valid)
);

// File: tb/sim_ramp_adc_ctrl.sv
// Self-checking bench: ideal DAC and comparator against an integer input.
module sim_ramp_adc_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       dir_down = 1'b0;
    logic       feedback = 1'b1;
    logic [7:0] tick_div = 8'd0;
    logic       cmp_in;
    logic [7:0] dac_code;
    logic [7:0] result;
    logic       valid;
    int         vin = 0;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    // Ideal DAC plus comparator, sense chosen by ramp direction.
    assign cmp_in = dir_down ? (int'(dac_code) <= vin) : (int'(dac_code) >= vin);

    ramp_adc_ctrl u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .dir_down(dir_down),
        .feedback(feedback),
        .tick_div(tick_div),
        .cmp_in  (cmp_in),
        .dac_code(dac_code),
        .result  (result),
        .valid   (valid)
    );

    localparam int NV = 10;
    localparam int T_VIN [NV] = '{100, 0, 37, 300, 200, 255, -5, 100, 50, 255};
    localparam int T_DIR [NV] = '{0, 0, 0, 0, 1, 1, 1, 0, 1, 0};
    localparam int T_FB  [NV] = '{1, 1, 1, 1, 1, 1, 1, 0, 0, 1};
    localparam int T_DIV [NV] = '{0, 0, 2, 0, 1, 0, 0, 0, 1, 0};
    localparam int T_RES [NV] = '{100, 0, 37, 255, 200, 255, 0, 100, 50, 255};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_valid(output int n, input int lim);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!valid && n < lim);
    endtask

    function automatic int exp_period(input int v, input int dn, input int fb, input int dv);
        int p;
        int t;
        int steps;
        p = dv + 1;
        if (fb == 0) return 256 * p;
        t = (v < 0) ? 0 : ((v > 255) ? 255 : v);
        steps = (dn != 0) ? (255 - t) : t;
        return (steps == 0) ? 4 : 6 + steps * p;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int n2;
        int bad;
        int r0;
        string tag;

        // R1: reset state.
        repeat (5) @(negedge clk);
        chk(dac_code == 8'd0, "R1 dac_code", dac_code, 0);
        chk(result == 8'd0, "R1 result", result, 0);
        chk(valid == 1'b0, "R1 valid", valid, 0);
        rst_n = 1'b1;

        // Table walk: R3/R5/R6 results, R4/R6 intervals, R7 pulse shape.
        for (int i = 0; i < NV; i++) begin
            run_en = 1'b0;
            dir_down = T_DIR[i][0];
            feedback = T_FB[i][0];
            tick_div = 8'(T_DIV[i]);
            vin = T_VIN[i];
            repeat (3) @(negedge clk);
            run_en = 1'b1;
            tag = (T_FB[i] == 0) ? "R6" : ((T_VIN[i] < 0 || T_VIN[i] > 255) ? "R5" : "R3");
            wait_valid(n, 3000);
            chk(valid == 1'b1, {tag, " first valid"}, valid, 1);
            chk(int'(result) == T_RES[i], {tag, " result"}, result, T_RES[i]);
            r0 = int'(result);
            @(negedge clk);
            chk(valid == 1'b0 && int'(result) == r0, "R7 pulse width", valid, 0);
            wait_valid(n2, 3000);
            chk(n2 + 1 == exp_period(T_VIN[i], T_DIR[i], T_FB[i], T_DIV[i]),
                (T_FB[i] != 0) ? "R4 interval" : "R6 interval",
                n2 + 1, exp_period(T_VIN[i], T_DIR[i], T_FB[i], T_DIV[i]));
            chk(int'(result) == T_RES[i], {tag, " repeat result"}, result, T_RES[i]);
        end

        // R2: step period and size with tick_div=3.
        run_en = 1'b0;
        dir_down = 1'b0;
        feedback = 1'b1;
        tick_div = 8'd3;
        vin = 300;
        repeat (3) @(negedge clk);
        run_en = 1'b1;
        n = 0;
        while (dac_code != 8'd5 && n < 200) begin
            @(negedge clk);
            n++;
        end
        n = 0;
        while (dac_code == 8'd5 && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(n == 4, "R2 step period", n, 4);
        chk(dac_code == 8'd6, "R2 step size", dac_code, 6);

        // R9: direction flip mid-ramp restarts from 255 on the next clock.
        dir_down = 1'b1;
        @(negedge clk);
        chk(dac_code == 8'd255, "R9 restart code", dac_code, 255);

        // R8: idle holds the start value with no valid.
        run_en = 1'b0;
        vin = 100;
        @(negedge clk);
        bad = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (dac_code != 8'd255 || valid) bad++;
        end
        chk(bad == 0, "R8 idle down", bad, 0);
        dir_down = 1'b0;
        @(negedge clk);
        chk(dac_code == 8'd0 && !valid, "R8 idle up", dac_code, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule